// File: doc/BRIEF.md
# Serial Flash Status Register and Write Guard

This block keeps the status byte of a serial flash device and decides, one command at a time, whether a state-changing request may proceed. A command decoder in front of it presents one decoded command per cycle (latch set, latch clear, status read, status write, page program, sector erase, bulk erase) together with the target address and, for a status write, the new status byte. The block answers every state-changing request with a one-cycle grant or deny pulse. A grant tells the array engine to start its cycle. The engine's busy line tells the block when that cycle has finished.

Protection works in three layers. First, a write enable latch must be set before any modifying command. Second, two block-protect bits fence off a region at the top of the address space against program and erase. Third, a status-write-disable bit, together with a low level on the active-low protect pin, freezes the protection bits themselves. The nonvolatile status bits are modelled as plain registers that load a parameterised value at reset. Serial shifting and array timing live in other blocks.

Top module: `flash_status_guard`

## Requirements
- R1: The status byte is {SRWD, 0, 0, 0, BP1, BP0, WEL, WIP}, with WIP in bit 0, WEL in bit 1, BP0 in bit 2, BP1 in bit 3 and SRWD in bit 7. Bits 6:4 always read 0. After reset the byte is 0x00 and no grant or deny is asserted.
- R2: Command codes are WREN=0, WRDI=1, RDSR=2, WRSR=3, PP=4, SE=5, BE=6, and 7 is no operation. WREN sets WEL and WRDI clears it. Either change is visible in the cycle after the command.
- R3: A WRSR, PP, SE or BE issued while WEL is 0 produces a deny pulse in the next cycle and changes no status bit.
- R4: An accepted WRSR, PP, SE or BE produces a grant pulse and sets WIP in the cycle after the command. WIP stays 1 until the busy input falls. WIP and WEL are both 0 in the cycle after the busy input is first seen low again.
- R5: BP1:BP0 protects addresses as follows: 00 protects nothing, 01 protects the top quarter, 10 protects the top half, and 11 protects all addresses. A PP or SE aimed at a protected address is denied, does not set WIP and leaves WEL at 1.
- R6: A BE is denied when either block-protect bit is 1. WEL is left unchanged.
- R7: An accepted WRSR loads SRWD from data bit 7, BP1 from data bit 3 and BP0 from data bit 2. The other data bits are ignored.
- R8: When SRWD is 1 and the active-low protect pin is 0, a WRSR is denied, SRWD, BP1, BP0 and WEL keep their values, and WIP stays 0.
- R9: While WIP is 1, every command except RDSR is ignored. WREN and WRDI leave WEL unchanged, and a modifying command produces a deny pulse.
- R10: RDSR produces neither grant nor deny and changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | A decoded command is present this cycle |
| cmd_op_i | input | 3 | Command code (see R2) |
| cmd_addr_i | input | ADDR_W | Target address for PP and SE |
| cmd_data_i | input | 8 | New status byte for WRSR |
| wp_n_i | input | 1 | Active-low write-protect pin |
| array_busy_i | input | 1 | Array engine is running a cycle |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Modifying command accepted (one-cycle pulse) |
| deny_o | output | 1 | Modifying command refused (one-cycle pulse) |
| wel_o | output | 1 | Write enable latch |

## Verification
The bench aims at the protection boundaries. It programs the last unprotected address and the first protected one for each block-protect setting. A design with an off-by-one limit either grants a program into the fenced region or refuses a legal one. It issues status writes with the protect pin low, both with SRWD set and with SRWD clear, so a design that ignores the pin, or ignores the bit, is caught by a deny or a changed BP value. While the engine is busy it injects latch and modifying commands, which catches a design that lets WREN or WRDI through during a cycle. It also checks that a refused program keeps WEL at 1, which a design that clears the latch on every attempt gets wrong.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

   typedef enum logic [2:0] {
      OP_WREN = 3'd0,
      OP_WRDI = 3'd1,
      OP_RDSR = 3'd2,
      OP_WRSR = 3'd3,
      OP_PP   = 3'd4,
      OP_SE   = 3'd5,
      OP_BE   = 3'd6,
      OP_NOP  = 3'd7
   } fsg_op_e;

   localparam int STAT_W   = 8;
   localparam int WIP_BIT  = 0;
   localparam int WEL_BIT  = 1;
   localparam int BP0_BIT  = 2;
   localparam int BP1_BIT  = 3;
   localparam int SRWD_BIT = 7;

   function automatic logic is_modify(input fsg_op_e op);
      return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) || (op == OP_BE);
   endfunction

endpackage

// File: rtl/fsg_prot_decode.sv
// Maps the two block-protect bits and a target address to a protected flag.
module fsg_prot_decode #(
   parameter int ADDR_W        = 16,
   parameter bit PROT_FROM_TOP = 1'b1
) (
   input  logic [1:0]        bp_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o,
   output logic              any_bp_o
);
   localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);
   localparam logic [ADDR_W-1:0] HALF    = ADDR_W'(1) << (ADDR_W - 1);
   localparam logic [ADDR_W-1:0] TOP_Q   = HALF + QUARTER;

   logic in_quarter, in_half;

   generate
      if (PROT_FROM_TOP) begin : g_top
         assign in_quarter = (addr_i >= TOP_Q);
         assign in_half    = (addr_i >= HALF);
      end else begin : g_bottom
         assign in_quarter = (addr_i < QUARTER);
         assign in_half    = (addr_i < HALF);
      end
   endgenerate

   always_comb begin
      unique case (bp_i)
         2'b00:   hit_o = 1'b0;
         2'b01:   hit_o = in_quarter;
         2'b10:   hit_o = in_half;
         default: hit_o = 1'b1;
      endcase
   end

   assign any_bp_o = |bp_i;
endmodule

// File: rtl/fsg_cycle_track.sv
// Samples the engine busy line and flags the end of a running cycle.
module fsg_cycle_track #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic busy_i,
   input  logic wip_i,
   output logic done_o
);
   logic busy_s;
   logic busy_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign busy_s = busy_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2:0], busy_i};
         end
         assign busy_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_q <= 1'b0;
      else        busy_q <= busy_s;
   end

   assign done_o = wip_i & busy_q & ~busy_s;
endmodule

// File: rtl/fsg_cmd_arbiter.sv
// Combinational accept/refuse decision for one decoded command.
module fsg_cmd_arbiter
   import fsg_pkg::*;
(
   input  logic    valid_i,
   input  fsg_op_e op_i,
   input  logic    wip_i,
   input  logic    wel_i,
   input  logic    srwd_i,
   input  logic    wp_n_i,
   input  logic    prot_hit_i,
   input  logic    any_bp_i,
   output logic    accept_o,
   output logic    refuse_o,
   output logic    set_wel_o,
   output logic    clr_wel_o,
   output logic    wr_stat_o
);
   logic modify, idle, allowed;

   assign modify = valid_i & is_modify(op_i);
   assign idle   = valid_i & ~wip_i;

   always_comb begin
      unique case (op_i)
         OP_WRSR: allowed = wel_i & ~(srwd_i & ~wp_n_i);
         OP_PP,
         OP_SE:   allowed = wel_i & ~prot_hit_i;
         OP_BE:   allowed = wel_i & ~any_bp_i;
         default: allowed = 1'b0;
      endcase
   end

   assign accept_o  = modify & ~wip_i & allowed;
   assign refuse_o  = modify & ~accept_o;
   assign set_wel_o = idle & (op_i == OP_WREN);
   assign clr_wel_o = idle & (op_i == OP_WRDI);
   assign wr_stat_o = accept_o & (op_i == OP_WRSR);
endmodule

// File: rtl/fsg_status_regs.sv
// Holds WIP, WEL, block-protect and write-disable bits.
module fsg_status_regs #(
   parameter logic [1:0] RESET_BP   = 2'b00,
   parameter bit         RESET_SRWD = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept_i,
   input  logic       set_wel_i,
   input  logic       clr_wel_i,
   input  logic       wr_stat_i,
   input  logic [2:0] new_prot_i,
   input  logic       done_i,
   output logic       wip_o,
   output logic       wel_o,
   output logic [1:0] bp_o,
   output logic       srwd_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip_o  <= 1'b0;
         wel_o  <= 1'b0;
         bp_o   <= RESET_BP;
         srwd_o <= RESET_SRWD;
      end else begin
         if (accept_i)    wip_o <= 1'b1;
         else if (done_i) wip_o <= 1'b0;

         if (done_i || clr_wel_i) wel_o <= 1'b0;
         else if (set_wel_i)      wel_o <= 1'b1;

         if (wr_stat_i) begin
            srwd_o <= new_prot_i[2];
            bp_o   <= new_prot_i[1:0];
         end
      end
   end
endmodule

// File: rtl/flash_status_guard.sv
module flash_status_guard
   import fsg_pkg::*;
#(
   parameter int         ADDR_W        = 16,
   parameter bit         PROT_FROM_TOP = 1'b1,
   parameter int         SYNC_STAGES   = 0,
   parameter logic [1:0] RESET_BP      = 2'b00,
   parameter bit         RESET_SRWD    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid_i,
   input  logic [2:0]        cmd_op_i,
   input  logic [ADDR_W-1:0] cmd_addr_i,
   input  logic [7:0]        cmd_data_i,
   input  logic              wp_n_i,
   input  logic              array_busy_i,
   output logic [7:0]        status_o,
   output logic              grant_o,
   output logic              deny_o,
   output logic              wel_o
);
   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("flash_status_guard: ADDR_W must be at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES == 1) begin : g_bad_sync
         $error("flash_status_guard: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   fsg_op_e    op;
   logic       wip, wel, srwd, done;
   logic [1:0] bp;
   logic       prot_hit, any_bp;
   logic       accept, refuse, set_wel, clr_wel, wr_stat;
   logic [2:0] new_prot;
   logic       grant_q, deny_q;
   logic       unused_data;

   assign op          = fsg_op_e'(cmd_op_i);
   assign new_prot    = {cmd_data_i[SRWD_BIT], cmd_data_i[BP1_BIT], cmd_data_i[BP0_BIT]};
   assign unused_data = ^{cmd_data_i[6:4], cmd_data_i[1:0]};

   fsg_prot_decode #(.ADDR_W(ADDR_W), .PROT_FROM_TOP(PROT_FROM_TOP)) u_prot (
      .bp_i     (bp),
      .addr_i   (cmd_addr_i),
      .hit_o    (prot_hit),
      .any_bp_o (any_bp)
   );

   fsg_cmd_arbiter u_arb (
      .valid_i    (cmd_valid_i),
      .op_i       (op),
      .wip_i      (wip),
      .wel_i      (wel),
      .srwd_i     (srwd),
      .wp_n_i     (wp_n_i),
      .prot_hit_i (prot_hit),
      .any_bp_i   (any_bp),
      .accept_o   (accept),
      .refuse_o   (refuse),
      .set_wel_o  (set_wel),
      .clr_wel_o  (clr_wel),
      .wr_stat_o  (wr_stat)
   );

   fsg_cycle_track #(.SYNC_STAGES(SYNC_STAGES)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .busy_i (array_busy_i),
      .wip_i  (wip),
      .done_o (done)
   );

   fsg_status_regs #(.RESET_BP(RESET_BP), .RESET_SRWD(RESET_SRWD)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept_i   (accept),
      .set_wel_i  (set_wel),
      .clr_wel_i  (clr_wel),
      .wr_stat_i  (wr_stat),
      .new_prot_i (new_prot),
      .done_i     (done),
      .wip_o      (wip),
      .wel_o      (wel),
      .bp_o       (bp),
      .srwd_o     (srwd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= 1'b0;
         deny_q  <= 1'b0;
      end else begin
         grant_q <= accept;
         deny_q  <= refuse;
      end
   end

   always_comb begin
      status_o           = '0;
      status_o[WIP_BIT]  = wip;
      status_o[WEL_BIT]  = wel;
      status_o[BP0_BIT]  = bp[0];
      status_o[BP1_BIT]  = bp[1];
      status_o[SRWD_BIT] = srwd;
   end

   assign grant_o = grant_q;
   assign deny_o  = deny_q;
   assign wel_o   = wel;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid_i,
   input logic [2:0] cmd_op_i,
   input logic       wp_n_i,
   input logic [7:0] status_o,
   input logic       grant_o,
   input logic       deny_o,
   input logic       wel_o
);
   logic is_wrsr, is_be;
   assign is_wrsr = cmd_valid_i && (cmd_op_i == 3'd3);
   assign is_be   = cmd_valid_i && (cmd_op_i == 3'd6);

   // R1
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[6:4] == 3'b000);

   // R1
   wel_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wel_o == status_o[1]);

   // R3
   grant_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> $past(status_o[1]));

   // R4
   grant_sets_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o |-> status_o[0]);

   // R4
   grant_deny_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o && deny_o));

   // R6
   be_fenced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_be && !status_o[0] && (status_o[3:2] != 2'b00)) |=> deny_o);

   // R8
   srwd_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wrsr && !status_o[0] && status_o[7] && !wp_n_i)
      |=> (deny_o && $stable(status_o[7]) && $stable(status_o[3:2]) && $stable(status_o[1])));

   // R9
   busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[0] && cmd_valid_i) |=> !grant_o);

   // R10
   rdsr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid_i && cmd_op_i == 3'd2) |=> (!grant_o && !deny_o));
endmodule

bind flash_status_guard fsg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid_i (cmd_valid_i),
   .cmd_op_i    (cmd_op_i),
   .wp_n_i      (wp_n_i),
   .status_o    (status_o),
   .grant_o     (grant_o),
   .deny_o      (deny_o),
   .wel_o       (wel_o)
);

// File: tb/sim_flash_status_guard.sv
`timescale 1ns/1ps
module sim_flash_status_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid_i = 1'b0;
   logic [2:0]  cmd_op_i = 3'd7;
   logic [15:0] cmd_addr_i = '0;
   logic [7:0]  cmd_data_i = '0;
   logic        wp_n_i = 1'b1;
   logic        array_busy_i = 1'b0;
   logic [7:0]  status_o;
   logic        grant_o, deny_o, wel_o;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // reference model state
   logic       m_wip = 0, m_wel = 0, m_srwd = 0;
   logic [1:0] m_bp = 0;

   always #2.5 clk = ~clk;

   flash_status_guard u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
      .cmd_addr_i(cmd_addr_i), .cmd_data_i(cmd_data_i), .wp_n_i(wp_n_i),
      .array_busy_i(array_busy_i), .status_o(status_o), .grant_o(grant_o),
      .deny_o(deny_o), .wel_o(wel_o)
   );

   function automatic logic [7:0] exp_status();
      return {m_srwd, 3'b000, m_bp, m_wel, m_wip};
   endfunction

   function automatic logic fenced(input logic [1:0] bp, input logic [15:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a >= 16'hC000;
         2'b10:   return a >= 16'h8000;
         default: return 1'b1;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] op);
      if (m_wip) return "R9";
      case (op)
         3'd0, 3'd1: return "R2";
         3'd2:       return "R10";
         3'd3:       return (m_srwd && !wp_n_i) ? "R8" : "R7";
         3'd4, 3'd5: return "R5";
         3'd6:       return "R6";
         default:    return "R1";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // drive at negedge, sample at following negedge
   task automatic drive(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d,
                        input logic eg, input logic ed, input string req);
      cmd_valid_i = 1'b1; cmd_op_i = op; cmd_addr_i = a; cmd_data_i = d;
      @(posedge clk); @(negedge clk);
      cmd_valid_i = 1'b0;
      check(req, "grant", {7'd0, grant_o}, {7'd0, eg});
      check(req, "deny",  {7'd0, deny_o},  {7'd0, ed});
      check(req, "status", status_o, exp_status());
   endtask

   task automatic run_engine(input bit inject);
      int n = 1 + int'($urandom % 4);
      for (int i = 0; i < n; i++) begin
         array_busy_i = 1'b1;
         if (inject) begin
            logic [2:0] op = 3'($urandom % 7);
            logic md = (op >= 3'd3) && (op != 3'd7) && (op != 3'd2);
            drive(op, 16'($urandom), 8'($urandom), 1'b0, md, (op == 3'd2) ? "R10" : "R9");
         end else begin
            @(posedge clk); @(negedge clk);
            check("R4", "wip held", status_o, exp_status());
         end
      end
      array_busy_i = 1'b0;
      @(posedge clk); @(negedge clk);
      m_wip = 0; m_wel = 0;
      check("R4", "cycle end", status_o, exp_status());
   endtask

   task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d, input bit inject);
      logic g = 0, dn = 0;
      string req = tag_of(op);
      if (!m_wel && op >= 3'd3 && op <= 3'd6) req = "R3";
      case (op)
         3'd0: m_wel = 1;
         3'd1: m_wel = 0;
         3'd3: if (m_wel && !(m_srwd && !wp_n_i)) begin
                  g = 1; m_srwd = d[7]; m_bp = {d[3], d[2]};
               end else dn = 1;
         3'd4, 3'd5: if (m_wel && !fenced(m_bp, a)) g = 1; else dn = 1;
         3'd6: if (m_wel && m_bp == 2'b00) g = 1; else dn = 1;
         default: ;
      endcase
      if (g) m_wip = 1;
      drive(op, a, d, g, dn, req);
      if (g) run_engine(inject);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1", "reset status", status_o, 8'h00);
      check("R1", "reset grant/deny", {6'd0, grant_o, deny_o}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      issue(3'd4, 16'h0010, 8'h00, 0);   // R3 program without latch
      issue(3'd6, 16'h0000, 8'h00, 0);   // R3 bulk erase without latch
      issue(3'd0, 16'h0000, 8'h00, 0);   // R2
      issue(3'd1, 16'h0000, 8'h00, 0);   // R2
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd4, 16'hFFFF, 8'h00, 0);   // R4 top address with BP=00
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd3, 16'h0000, 8'hF7, 0);   // R7 srwd=1 bp=01, stray bits ignored
      issue(3'd2, 16'h0000, 8'h00, 0);   // R10
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd4, 16'hC000, 8'h00, 0);   // R5 first fenced address, WEL kept
      issue(3'd5, 16'hBFFF, 8'h00, 0);   // R5 last open address
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd6, 16'h0000, 8'h00, 0);   // R6 bulk erase fenced
      wp_n_i = 1'b0;
      issue(3'd3, 16'h0000, 8'h08, 0);   // R8 frozen
      wp_n_i = 1'b1;
      issue(3'd3, 16'h0000, 8'h08, 1);   // R7 bp=10 srwd=0, R9 injections
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd4, 16'h8000, 8'h00, 0);   // R5 half fenced
      issue(3'd4, 16'h7FFF, 8'h00, 0);   // R5 open
      issue(3'd0, 16'h0000, 8'h00, 0);
      wp_n_i = 1'b0;
      issue(3'd3, 16'h0000, 8'h0C, 0);   // R7 srwd=0 so pin has no effect
      wp_n_i = 1'b1;
      issue(3'd0, 16'h0000, 8'h00, 0);
      issue(3'd5, 16'h0000, 8'h00, 0);   // R5 everything fenced

      for (int k = 0; k < 600; k++) begin
         logic [2:0] op;
         int r = int'($urandom % 10);
         op = (r < 3) ? 3'd0 : 3'($urandom % 8);
         wp_n_i = ($urandom % 3) != 0;
         issue(op, 16'($urandom), 8'($urandom), ($urandom % 2) == 1);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule